// File: doc/BRIEF.md
# Eight-Bit Arithmetic and Logic Unit with Condition Flags

This block is the purely combinational datapath of a small eight-bit microcontroller core. Each cycle the core presents an operation code, two operands (the accumulator value and a second operand), and the current carry and half-carry flags. The unit returns the eight-bit result, the new zero, carry, half-carry and overflow flags, and a per-flag update mask. The core uses the mask to write only the flags that the operation is meant to change.

A separate zero-detect output reports whether the result is all zeros for every operation, including those that leave the Z flag untouched. Skip-if-zero branch decisions use this output. Subtraction uses the "no borrow" convention: carry and half-carry read 1 when no borrow took place. Decimal adjust corrects the accumulator after adding two packed BCD bytes.

Top module: `alu8_core`

## Requirements
- R1: Codes 0 (ADD) and 1 (ADC) return A+B and A+B+carry_in. C is the carry out of bit 7.
- R2: Codes 2 (SUB) and 3 (SBC) return A+~B+1 and A+~B+carry_in. C is 1 exactly when no borrow occurs, that is A≥B for SUB and A>B, or A==B with carry_in=1, for SBC.
- R3: For codes 0–3, AC is the carry out of bit 3 of the same sum. In subtraction this means the low nibble needed no borrow.
- R4: For codes 0–3, OV is 1 when the carry into bit 7 differs from the carry out of bit 7, which is the same as signed overflow.
- R5: Code 4 (DAA) adds 06h when A's low nibble exceeds 9 or half-carry_in is 1. It then adds 60h when the corrected high nibble exceeds 9, carry_in is 1, or the first step overflowed. C is carry_in ORed with any overflow. Only Z and C are updated.
- R6: Codes 5 (AND), 6 (OR) and 7 (XOR) combine A and B bitwise. Code 8 (CPL) inverts A. Only Z is updated.
- R7: Codes 9 (RL) and 10 (RR) rotate A left or right, with bit 7 and bit 0 wrapping around. No flag is updated.
- R8: Code 11 (RLC) rotates A left through carry and code 12 (RRC) rotates right through carry. carry_in fills the vacated bit, and the bit shifted out becomes C. Only C is updated.
- R9: Codes 13 (INC) and 14 (DEC) return A+1 and A−1 modulo 256. Only Z is updated.
- R10: flags_o and upd_o use the bit order {Z,C,AC,OV}, bit 3 to bit 0. Each flag whose upd_o bit is 0 is driven 0. Code 15 is reserved: it returns A and updates no flag.
- R11: zero_o is 1 exactly when res_o is 00h, for every code. When Z is updated, Z equals zero_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 4 | Operation code |
| a_i | input | 8 | First operand (accumulator) |
| b_i | input | 8 | Second operand |
| c_i | input | 1 | Current carry flag |
| ac_i | input | 1 | Current half-carry flag |
| res_o | output | 8 | Result |
| flags_o | output | 4 | New flags {Z,C,AC,OV} |
| upd_o | output | 4 | Flags affected by the operation {Z,C,AC,OV} |
| zero_o | output | 1 | Result is zero |

## Verification
The assertions are immediate checks evaluated on settled combinational values. They assume the inputs carry two-state values and stay stable while outputs are sampled. The borrow and signed-overflow checks also assume that the operation code selects the adder's operand inversion and carry source, as R1–R4 describe. The bench changes inputs only just after a rising clock edge and reads outputs at the following falling edge. Every vector uses defined 0/1 values, including the reserved code, so no check observes an unknown or mid-transition value.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    localparam int unsigned DW  = 8;
    localparam int unsigned NW  = DW / 2;
    localparam int unsigned OPW = 4;
    localparam int unsigned FW  = 4;

    typedef enum logic [OPW-1:0] {
        OP_ADD = 4'd0,  OP_ADC = 4'd1,  OP_SUB = 4'd2,  OP_SBC = 4'd3,
        OP_DAA = 4'd4,  OP_AND = 4'd5,  OP_OR  = 4'd6,  OP_XOR = 4'd7,
        OP_CPL = 4'd8,  OP_RL  = 4'd9,  OP_RR  = 4'd10, OP_RLC = 4'd11,
        OP_RRC = 4'd12, OP_INC = 4'd13, OP_DEC = 4'd14, OP_RSV = 4'd15
    } alu_op_e;

    typedef struct packed {
        logic z;
        logic c;
        logic ac;
        logic ov;
    } alu_flags_t;

    typedef struct packed {
        logic [DW-1:0] sum;
        logic          cout;
        logic          hcout;
        logic          ov;
    } add_res_t;

    localparam alu_flags_t FL_NONE  = '{z: 1'b0, c: 1'b0, ac: 1'b0, ov: 1'b0};
    localparam alu_flags_t FL_ALL   = '{z: 1'b1, c: 1'b1, ac: 1'b1, ov: 1'b1};
    localparam alu_flags_t FL_Z     = '{z: 1'b1, c: 1'b0, ac: 1'b0, ov: 1'b0};
    localparam alu_flags_t FL_C     = '{z: 1'b0, c: 1'b1, ac: 1'b0, ov: 1'b0};
    localparam alu_flags_t FL_ZC    = '{z: 1'b1, c: 1'b1, ac: 1'b0, ov: 1'b0};

    // Full adder with nibble carry and carry into the top bit.
    function automatic add_res_t add_full(input logic [DW-1:0] x,
                                          input logic [DW-1:0] y,
                                          input logic          ci);
        add_res_t        r;
        logic [NW:0]     lo;
        logic [DW-1:0]   low;
        logic [DW:0]     full;
        lo   = {1'b0, x[NW-1:0]} + {1'b0, y[NW-1:0]} + (NW+1)'(ci);
        low  = {1'b0, x[DW-2:0]} + {1'b0, y[DW-2:0]} + DW'(ci);
        full = {1'b0, x} + {1'b0, y} + (DW+1)'(ci);
        r.sum   = full[DW-1:0];
        r.cout  = full[DW];
        r.hcout = lo[NW];
        r.ov    = low[DW-1] ^ full[DW];
        return r;
    endfunction

endpackage

// File: rtl/alu8_arith.sv
module alu8_arith
    import alu8_pkg::*;
#(
    parameter int unsigned W = DW
) (
    input  alu_op_e    op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic       cin,
    input  logic       acin,
    output logic [W-1:0] res,
    output alu_flags_t flg,
    output alu_flags_t msk
);
    localparam int unsigned NB = W / 2;
    localparam logic [W:0] LO_FIX = (W+1)'(6);
    localparam logic [W:0] HI_FIX = (W+1)'(6) << NB;

    add_res_t   ar;
    logic [W-1:0] opb;
    logic       opc;
    logic       lo_adj, hi_adj;
    logic [W:0] t1, t2;

    always_comb begin
        opb = b;
        opc = 1'b0;
        unique case (op)
            OP_ADC:  opc = cin;
            OP_SUB:  begin opb = ~b; opc = 1'b1; end
            OP_SBC:  begin opb = ~b; opc = cin;  end
            OP_INC:  begin opb = '0; opc = 1'b1; end
            OP_DEC:  begin opb = '1; opc = 1'b0; end
            default: ;
        endcase
    end

    assign ar = add_full(a, opb, opc);

    // Decimal correction in two steps
    always_comb begin
        lo_adj = (a[NB-1:0] > NB'(9)) | acin;
        t1     = {1'b0, a} + (lo_adj ? LO_FIX : '0);
        hi_adj = (t1[W-1:NB] > NB'(9)) | cin | t1[W];
        t2     = {1'b0, t1[W-1:0]} + (hi_adj ? HI_FIX : '0);
    end

    always_comb begin
        res = ar.sum;
        flg = FL_NONE;
        msk = FL_NONE;
        unique case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC: begin
                flg.c  = ar.cout;
                flg.ac = ar.hcout;
                flg.ov = ar.ov;
                msk    = FL_ALL;
            end
            OP_DAA: begin
                res   = t2[W-1:0];
                flg.c = cin | t1[W] | t2[W];
                msk   = FL_ZC;
            end
            OP_INC, OP_DEC: msk = FL_Z;
            default: begin
                res = a;
            end
        endcase
    end

    always_comb begin
        // R2
        sub_noborrow_chk: assert (!(op == OP_SUB) || (flg.c == (a >= b)))
            else $error("SUB carry disagrees with no-borrow rule");
        // R2
        sbc_noborrow_chk: assert (!(op == OP_SBC) ||
                                  (flg.c == ((a > b) || ((a == b) && cin))))
            else $error("SBC carry disagrees with no-borrow rule");
        // R4
        signed_ovf_chk: assert (!(op == OP_ADD || op == OP_ADC) ||
                                (flg.ov == ((a[W-1] == b[W-1]) && (res[W-1] != a[W-1]))))
            else $error("ADD overflow disagrees with signed rule");
        // R3
        half_carry_chk: assert (!(op == OP_ADD) ||
                                (flg.ac == ((NB+1)'(a[NB-1:0]) + (NB+1)'(b[NB-1:0]) > (NB+1)'(15))))
            else $error("ADD half carry wrong");
    end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
    import alu8_pkg::*;
#(
    parameter int unsigned W = DW
) (
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] res
);
    always_comb begin
        unique case (op)
            OP_AND:  res = a & b;
            OP_OR:   res = a | b;
            OP_XOR:  res = a ^ b;
            OP_CPL:  res = ~a;
            default: res = a;
        endcase
    end
endmodule

// File: rtl/alu8_rot.sv
module alu8_rot
    import alu8_pkg::*;
#(
    parameter int unsigned W = DW
) (
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic         cin,
    output logic [W-1:0] res,
    output logic         cout
);
    always_comb begin
        cout = 1'b0;
        unique case (op)
            OP_RL:   res = {a[W-2:0], a[W-1]};
            OP_RR:   res = {a[0], a[W-1:1]};
            OP_RLC:  begin res = {a[W-2:0], cin}; cout = a[W-1]; end
            OP_RRC:  begin res = {cin, a[W-1:1]}; cout = a[0];   end
            default: res = a;
        endcase
    end

    always_comb begin
        // R7
        wrap_bits_chk: assert (!(op == OP_RL || op == OP_RR) ||
                               ($countones(res) == $countones(a)))
            else $error("plain rotate lost or gained a bit");
        // R8
        thru_carry_chk: assert (!(op == OP_RLC || op == OP_RRC) ||
                                ($countones({res, cout}) == $countones({a, cin})))
            else $error("rotate through carry lost or gained a bit");
    end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
#(
    parameter int unsigned W = DW
) (
    input  logic [OPW-1:0] op_i,
    input  logic [W-1:0]   a_i,
    input  logic [W-1:0]   b_i,
    input  logic           c_i,
    input  logic           ac_i,
    output logic [W-1:0]   res_o,
    output logic [FW-1:0]  flags_o,
    output logic [FW-1:0]  upd_o,
    output logic           zero_o
);
    typedef enum logic [1:0] { U_ARITH, U_LOGIC, U_ROT, U_PASS } unit_e;

    alu_op_e      op;
    unit_e        unit;
    logic [W-1:0] ar_res, lg_res, rt_res;
    alu_flags_t   ar_flg, ar_msk;
    logic         rt_c;
    alu_flags_t   flg, msk;
    logic [W-1:0] res;

    assign op = alu_op_e'(op_i);

    always_comb begin
        unique case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC,
            OP_DAA, OP_INC, OP_DEC:              unit = U_ARITH;
            OP_AND, OP_OR, OP_XOR, OP_CPL:       unit = U_LOGIC;
            OP_RL, OP_RR, OP_RLC, OP_RRC:        unit = U_ROT;
            default:                             unit = U_PASS;
        endcase
    end

    alu8_arith #(.W(W)) u_arith (
        .op(op), .a(a_i), .b(b_i), .cin(c_i), .acin(ac_i),
        .res(ar_res), .flg(ar_flg), .msk(ar_msk)
    );

    alu8_logic #(.W(W)) u_logic (
        .op(op), .a(a_i), .b(b_i), .res(lg_res)
    );

    alu8_rot #(.W(W)) u_rot (
        .op(op), .a(a_i), .cin(c_i), .res(rt_res), .cout(rt_c)
    );

    always_comb begin
        res = a_i;
        flg = FL_NONE;
        msk = FL_NONE;
        unique case (unit)
            U_ARITH: begin res = ar_res; flg = ar_flg; msk = ar_msk; end
            U_LOGIC: begin res = lg_res; msk = FL_Z; end
            U_ROT: begin
                res = rt_res;
                if (op == OP_RLC || op == OP_RRC) begin
                    flg.c = rt_c;
                    msk   = FL_C;
                end
            end
            default: ;
        endcase
    end

    assign zero_o  = ~|res;
    assign res_o   = res;
    assign upd_o   = msk;
    assign flags_o = {msk.z & zero_o, flg.c & msk.c, flg.ac & msk.ac, flg.ov & msk.ov};

    always_comb begin
        // R5
        daa_range_chk: assert (!(op == OP_DAA && a_i[3:0] <= 4'd9 && a_i[7:4] <= 4'd9
                                 && !c_i && !ac_i) || (res_o[3:0] <= 4'd9 && res_o[7:4] <= 4'd9))
            else $error("decimal adjust left a non-BCD digit");
        // R10
        pass_thru_chk: assert (!(op == OP_RSV) || (res_o == a_i && upd_o == '0))
            else $error("reserved code altered result or flags");
    end
endmodule

// File: tb/test_alu8_core.sv
module test_alu8_core;
    logic       clk = 1'b0;
    logic [3:0] op;
    logic [7:0] a, b;
    logic       ci, aci;
    logic [7:0] res;
    logic [3:0] flags, upd;
    logic       zero;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    alu8_core i_alu8_core (
        .op_i(op), .a_i(a), .b_i(b), .c_i(ci), .ac_i(aci),
        .res_o(res), .flags_o(flags), .upd_o(upd), .zero_o(zero)
    );

    // {op, a, b, c_in, ac_in, result, flags ZC-AC-OV, mask ZC-AC-OV}
    localparam int NV = 26;
    localparam logic [37:0] VEC [NV] = '{
        {4'd0,  8'h3A, 8'h26, 1'b0, 1'b0, 8'h60, 4'b0010, 4'b1111}, // R1 R3
        {4'd0,  8'hFF, 8'h01, 1'b0, 1'b0, 8'h00, 4'b1110, 4'b1111}, // R1
        {4'd0,  8'h7F, 8'h01, 1'b0, 1'b0, 8'h80, 4'b0011, 4'b1111}, // R4
        {4'd1,  8'h10, 8'h20, 1'b1, 1'b0, 8'h31, 4'b0000, 4'b1111}, // R1
        {4'd2,  8'h50, 8'h30, 1'b0, 1'b0, 8'h20, 4'b0110, 4'b1111}, // R2
        {4'd2,  8'h30, 8'h50, 1'b0, 1'b0, 8'hE0, 4'b0010, 4'b1111}, // R2
        {4'd2,  8'h80, 8'h01, 1'b0, 1'b0, 8'h7F, 4'b0101, 4'b1111}, // R4
        {4'd3,  8'h05, 8'h05, 1'b0, 1'b0, 8'hFF, 4'b0000, 4'b1111}, // R2
        {4'd3,  8'h05, 8'h05, 1'b1, 1'b0, 8'h00, 4'b1110, 4'b1111}, // R2
        {4'd4,  8'h3C, 8'h00, 1'b0, 1'b0, 8'h42, 4'b0000, 4'b1100}, // R5
        {4'd4,  8'h9A, 8'h00, 1'b0, 1'b0, 8'h00, 4'b1100, 4'b1100}, // R5
        {4'd4,  8'h12, 8'h00, 1'b0, 1'b1, 8'h18, 4'b0000, 4'b1100}, // R5
        {4'd4,  8'h21, 8'h00, 1'b1, 1'b0, 8'h81, 4'b0100, 4'b1100}, // R5
        {4'd5,  8'hF0, 8'h0F, 1'b1, 1'b1, 8'h00, 4'b1000, 4'b1000}, // R6
        {4'd6,  8'hA0, 8'h05, 1'b1, 1'b0, 8'hA5, 4'b0000, 4'b1000}, // R6
        {4'd7,  8'h5A, 8'h5A, 1'b0, 1'b0, 8'h00, 4'b1000, 4'b1000}, // R6
        {4'd8,  8'h5A, 8'hFF, 1'b0, 1'b0, 8'hA5, 4'b0000, 4'b1000}, // R6
        {4'd9,  8'h81, 8'h00, 1'b1, 1'b0, 8'h03, 4'b0000, 4'b0000}, // R7
        {4'd10, 8'h81, 8'h00, 1'b1, 1'b0, 8'hC0, 4'b0000, 4'b0000}, // R7
        {4'd11, 8'h80, 8'h00, 1'b0, 1'b0, 8'h00, 4'b0100, 4'b0100}, // R8
        {4'd12, 8'h01, 8'h00, 1'b1, 1'b0, 8'h80, 4'b0100, 4'b0100}, // R8
        {4'd11, 8'h40, 8'h00, 1'b1, 1'b0, 8'h81, 4'b0000, 4'b0100}, // R8
        {4'd13, 8'hFF, 8'h00, 1'b1, 1'b1, 8'h00, 4'b1000, 4'b1000}, // R9
        {4'd14, 8'h00, 8'h00, 1'b0, 1'b0, 8'hFF, 4'b0000, 4'b1000}, // R9
        {4'd13, 8'h41, 8'h00, 1'b0, 1'b0, 8'h42, 4'b0000, 4'b1000}, // R9
        {4'd15, 8'h33, 8'hCC, 1'b1, 1'b1, 8'h33, 4'b0000, 4'b0000}  // R10
    };

    function automatic string req_of(input logic [3:0] code);
        case (code)
            4'd0, 4'd1:               return "R1";
            4'd2, 4'd3:               return "R2";
            4'd4:                     return "R5";
            4'd5, 4'd6, 4'd7, 4'd8:   return "R6";
            4'd9, 4'd10:              return "R7";
            4'd11, 4'd12:             return "R8";
            4'd13, 4'd14:             return "R9";
            default:                  return "R10";
        endcase
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %02h expected %02h (op %0d a %02h b %02h)",
                     req, act, exp, op, a, b);
        end
    endtask

    task automatic apply(input logic [3:0] o, input logic [7:0] x, input logic [7:0] y,
                         input logic c, input logic h);
        @(posedge clk);
        op = o; a = x; b = y; ci = c; aci = h;
        @(negedge clk);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    initial begin
        op = '0; a = '0; b = '0; ci = 1'b0; aci = 1'b0;
        @(negedge clk);
        // Idle inputs: ADD of zeros gives zero result with Z set (R11, R1)
        chk("R1", res, 8'h00);
        chk("R11", {7'd0, zero}, 8'h01);
        chk("R10", {4'd0, flags}, 8'h08);

        for (int i = 0; i < NV; i++) begin
            logic [37:0] v;
            v = VEC[i];
            apply(v[37:34], v[33:26], v[25:18], v[17], v[16]);
            chk(req_of(v[37:34]), res, v[15:8]);
            chk("R10 flags", {4'd0, flags}, {4'd0, v[7:4]});
            chk("R10 mask", {4'd0, upd}, {4'd0, v[3:0]});
            chk("R11", {7'd0, zero}, {7'd0, (v[15:8] == 8'h00)});
        end

        // Sweep: SUB carry as no-borrow, SBC with borrow in
        for (int x = 0; x < 256; x++) begin
            apply(4'd2, 8'(x), 8'h80, 1'b0, 1'b0);
            chk("R2 sub C", {7'd0, flags[2]}, {7'd0, (x >= 128)});
            apply(4'd3, 8'(x), 8'h80, 1'b0, 1'b0);
            chk("R2 sbc", res, 8'(x - 129));
        end

        // Sweep: half carry and signed overflow on ADD
        for (int x = 0; x < 256; x++) begin
            logic [7:0] y;
            logic [7:0] s;
            y = 8'(x * 37 + 11);
            s = 8'(x) + y;
            apply(4'd0, 8'(x), y, 1'b0, 1'b0);
            chk("R3 ac", {7'd0, flags[1]}, {7'd0, ((x % 16) + (y % 16) > 15)});
            chk("R4 ov", {7'd0, flags[0]},
                {7'd0, (x[7] == y[7]) && (s[7] != x[7])});
        end

        // Zero detect without a Z update: RL of zero
        apply(4'd9, 8'h00, 8'h00, 1'b1, 1'b0);
        chk("R11 rl", {7'd0, zero}, 8'h01);
        chk("R7 no flags", {4'd0, flags}, 8'h00);

        summary();
    end
endmodule